// File: doc/BRIEF.md
# Handshaked Shift FIFO with Occupancy Flags

This block is a first-in first-out buffer of 64 words, 5 bits each. A producer offers a word by pulsing a shift-in strobe while the input-ready handshake is high. A consumer takes the word at the head by pulsing a shift-out strobe while the output-ready handshake is high. Both strobes are sampled on one clock as single-cycle pulses. A pulse that arrives while its ready signal is low is dropped. After each accepted transfer the ready signal on that side stays low for one clock, which models the busy time of a write or read cycle. Because of this pulse-and-ready behaviour on both sides, several units can be chained, each unit's output-ready driving the next unit's shift-in.

Two flags report occupancy. The half-full flag is high when 32 or more words are stored. A single combined flag is high when the buffer is nearly full (56 or more words) or nearly empty (8 or fewer words). An active-low master reset empties the buffer. An active-low output enable gates the data outputs. The high-impedance state of a shared bus is modelled by a per-bit drive mask and zeroed data.

Top module: `shift_fifo`

## Requirements
- R1: While `mrst_n` is low and on release, the buffer is empty: `in_rdy`=1, `out_rdy`=0, `half_full`=0, `almost_fe`=1.
- R2: A `shift_in` pulse sampled while `in_rdy`=1 stores `din`. `in_rdy` is then 0 for exactly the next clock, and afterwards it is 1 again if fewer than 64 words are stored.
- R3: With 64 words stored, `in_rdy` stays 0. A `shift_in` pulse while `in_rdy`=0 is ignored: no word is added.
- R4: Words leave in the order they were accepted. `dout` shows the head word whenever `out_rdy`=1 and `oe_n`=0.
- R5: `out_rdy` is 0 when the buffer is empty and for exactly one clock after an accepted `shift_out`. A `shift_out` pulse while `out_rdy`=0 is ignored.
- R6: `half_full` is 1 exactly when the stored count is 32 or more.
- R7: `almost_fe` is 1 exactly when the stored count is 56 or more, or 8 or fewer.
- R8: With `oe_n`=1, `dout` is all zeros and `dout_drive` is all zeros. With `oe_n`=0, `dout_drive` is all ones.
- R9: When a write and a read are accepted in the same clock, the stored count is unchanged and both words are handled in order.
- R10: Pulling `mrst_n` low while words are stored discards all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| shift_in | input | 1 | Write strobe, one-cycle pulse |
| din | input | 5 | Write data |
| in_rdy | output | 1 | Space available, write may be offered |
| shift_out | input | 1 | Read strobe, one-cycle pulse |
| out_rdy | output | 1 | Head word valid on `dout` |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 5 | Head word, zero when not enabled |
| dout_drive | output | 5 | Per-bit drive mask, ones when enabled |
| half_full | output | 1 | Count is 32 or more |
| almost_fe | output | 1 | Count is 56 or more, or 8 or fewer |

## Verification
The hardest case to reach is a write and a read accepted in the same clock. Both busy intervals must have ended together, and the buffer must be neither empty nor full. The stimulus first fills the buffer to the half-full boundary. It then issues a combined task that waits until both ready signals are high and pulses both strobes in one cycle. The bench checks that the half-full flag does not toggle and that the order of the words is preserved. Ignored strobes are placed in the busy clock right after an accepted write, and also at full and at empty. A later full drain then shows whether any extra word slipped in.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;

  parameter int DEF_DEPTH = 64;
  parameter int DEF_WIDTH = 5;

  // count at or above which the buffer reports half full
  function automatic int half_level(input int depth);
    return depth / 2;
  endfunction

  // count at or above which the buffer is nearly full
  function automatic int upper_level(input int depth);
    return depth - depth / 8;
  endfunction

  // count at or below which the buffer is nearly empty
  function automatic int lower_level(input int depth);
    return depth / 8;
  endfunction

  // pointer advance with wrap at depth
  function automatic int ptr_step(input int p, input int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/shift_fifo_store.sv
module shift_fifo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 5,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] cells [DEPTH];

  // one register row per entry, cleared by master reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk or negedge mrst_n) begin
      if (!mrst_n) begin
        cells[g] <= '0;
      end else if (wr_en && (wr_addr == AW'(g))) begin
        cells[g] <= wr_data;
      end
    end
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/shift_fifo_ctrl.sv
module shift_fifo_ctrl
  import shift_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          shift_in,
  input  logic          shift_out,
  output logic          in_rdy,
  output logic          out_rdy,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic in_busy_q;
  logic out_busy_q;

  assign in_rdy  = !in_busy_q  && (count != FULL_CNT);
  assign out_rdy = !out_busy_q && (count != '0);
  assign wr_acc  = shift_in  && in_rdy;
  assign rd_acc  = shift_out && out_rdy;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      in_busy_q  <= 1'b0;
      out_busy_q <= 1'b0;
    end else begin
      in_busy_q  <= wr_acc;
      out_busy_q <= rd_acc;
      if (wr_acc) wr_ptr <= AW'(ptr_step(int'(wr_ptr), DEPTH));
      if (rd_acc) rd_ptr <= AW'(ptr_step(int'(rd_ptr), DEPTH));
      case ({wr_acc, rd_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/shift_fifo_flags.sv
module shift_fifo_flags
  import shift_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input  logic [CW-1:0] count,
  output logic          half_full,
  output logic          almost_fe
);

  localparam int HALF_LVL = half_level(DEPTH);
  localparam int UP_LVL   = upper_level(DEPTH);
  localparam int LO_LVL   = lower_level(DEPTH);

  int n;
  assign n = int'(count);

  assign half_full = (n >= HALF_LVL);
  assign almost_fe = (n >= UP_LVL) || (n <= LO_LVL);

endmodule

// File: rtl/shift_fifo_outdrv.sv
module shift_fifo_outdrv #(
  parameter int WIDTH = 5
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_drive
);

  assign dout_drive = oe_n ? '0 : '1;
  assign dout       = word & dout_drive;

endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import shift_fifo_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shift_out,
  output logic             out_rdy,
  input  logic             oe_n,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_drive,
  output logic             half_full,
  output logic             almost_fe
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic             wr_acc;
  logic             rd_acc;
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [CW-1:0]    count;
  logic [WIDTH-1:0] head_word;

  shift_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .mrst_n(mrst_n), .shift_in(shift_in), .shift_out(shift_out),
    .in_rdy(in_rdy), .out_rdy(out_rdy), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  shift_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk(clk), .mrst_n(mrst_n), .wr_en(wr_acc), .wr_addr(wr_ptr),
    .wr_data(din), .rd_addr(rd_ptr), .rd_data(head_word)
  );

  shift_fifo_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .count(count), .half_full(half_full), .almost_fe(almost_fe)
  );

  shift_fifo_outdrv #(.WIDTH(WIDTH)) u_out (
    .oe_n(oe_n), .word(head_word), .dout(dout), .dout_drive(dout_drive)
  );

endmodule

// File: rtl/shift_fifo_checker.sv
module shift_fifo_checker #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 5,
  parameter int CW    = 7
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic             wr_acc,
  input logic             rd_acc,
  input logic [CW-1:0]    count,
  input logic             oe_n,
  input logic [WIDTH-1:0] dout_drive,
  input logic             half_full
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  assert_inrdy_busy_R2: assert property (@(posedge clk) disable iff (!mrst_n)
    wr_acc |=> !in_rdy);

  assert_full_block_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    (count == FULL_CNT) |-> !in_rdy);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    count <= FULL_CNT);

  assert_outrdy_busy_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    rd_acc |=> !out_rdy);

  assert_empty_block_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    (count == '0) |-> !out_rdy);

  assert_hf_rise_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(half_full) |-> (count == HALF_CNT));

  assert_float_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    oe_n |-> (dout_drive == '0));

  assert_pair_hold_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    (wr_acc && rd_acc) |=> $stable(count));

endmodule

bind shift_fifo shift_fifo_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .in_rdy(in_rdy), .out_rdy(out_rdy),
  .wr_acc(wr_acc), .rd_acc(rd_acc), .count(count), .oe_n(oe_n),
  .dout_drive(dout_drive), .half_full(half_full)
);

// File: tb/shift_fifo_test.sv
module shift_fifo_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int WIDTH = 5;

  logic             clk = 1'b0;
  logic             mrst_n = 1'b0;
  logic             shift_in = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic             in_rdy;
  logic             shift_out = 1'b0;
  logic             out_rdy;
  logic             oe_n = 1'b0;
  logic [WIDTH-1:0] dout;
  logic [WIDTH-1:0] dout_drive;
  logic             half_full;
  logic             almost_fe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [WIDTH-1:0] sb [$];

  shift_fifo uut (
    .clk(clk), .mrst_n(mrst_n), .shift_in(shift_in), .din(din),
    .in_rdy(in_rdy), .shift_out(shift_out), .out_rdy(out_rdy),
    .oe_n(oe_n), .dout(dout), .dout_drive(dout_drive),
    .half_full(half_full), .almost_fe(almost_fe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected flags from the stored count held by the scoreboard
  task automatic chk_flags();
    int n = sb.size();
    chk("R6 half_full", int'(half_full), int'(n > 31));
    chk("R7 almost_fe", int'(almost_fe), int'((n < 9) || (n > 55)));
  endtask

  // driver: offer one word, optionally strobe junk in the busy clock
  task automatic put(input logic [WIDTH-1:0] w, input bit junk);
    while (!in_rdy) @(negedge clk);
    din = w; shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
    sb.push_back(w);
    chk("R2 busy", int'(in_rdy), 0);
    chk_flags();
    if (junk) begin
      din = ~w; shift_in = 1'b1;
      @(negedge clk);
      shift_in = 1'b0;
      chk("R2 ready again", int'(in_rdy), int'(sb.size() < DEPTH));
    end
  endtask

  // monitor: compare head with scoreboard, then take it
  task automatic take();
    logic [WIDTH-1:0] exp_w;
    while (!out_rdy) @(negedge clk);
    exp_w = sb.pop_front();
    chk("R4 order", int'(dout), int'(exp_w));
    shift_out = 1'b1;
    @(negedge clk);
    shift_out = 1'b0;
    chk("R5 busy", int'(out_rdy), 0);
    chk_flags();
  endtask

  task automatic both(input logic [WIDTH-1:0] w);
    logic [WIDTH-1:0] exp_w;
    while (!(in_rdy && out_rdy)) @(negedge clk);
    exp_w = sb.pop_front();
    chk("R9 head", int'(dout), int'(exp_w));
    din = w; shift_in = 1'b1; shift_out = 1'b1;
    @(negedge clk);
    shift_in = 1'b0; shift_out = 1'b0;
    sb.push_back(w);
    chk("R9 in busy", int'(in_rdy), 0);
    chk("R9 out busy", int'(out_rdy), 0);
    chk_flags();
  endtask

  task automatic chk_empty(input string tag);
    chk({tag, " in_rdy"}, int'(in_rdy), 1);
    chk({tag, " out_rdy"}, int'(out_rdy), 0);
    chk({tag, " half_full"}, int'(half_full), 0);
    chk({tag, " almost_fe"}, int'(almost_fe), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_empty("R1 in reset");
    mrst_n = 1'b1;
    @(negedge clk);
    chk_empty("R1 after release");

    // R5: read strobe while empty is dropped
    shift_out = 1'b1;
    @(negedge clk);
    shift_out = 1'b0;
    @(negedge clk);
    chk("R5 ignored read", int'(out_rdy), 0);

    // R2/R3/R4: short burst with junk in busy clocks
    for (int i = 0; i < 5; i++) put(WIDTH'(i + 3), 1'b1);
    for (int i = 0; i < 5; i++) take();
    @(negedge clk);
    chk("R3 no junk stored", int'(out_rdy), 0);

    // fill to full across all flag boundaries
    for (int i = 0; i < DEPTH; i++) put(WIDTH'(i * 7 + 1), 1'b0);
    repeat (2) @(negedge clk);
    chk("R3 full in_rdy", int'(in_rdy), 0);
    din = 5'h1f; shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
    chk("R3 full stays", int'(in_rdy), 0);
    // R8: float outputs while holding data
    oe_n = 1'b1;
    @(negedge clk);
    chk("R8 dout zero", int'(dout), 0);
    chk("R8 mask zero", int'(dout_drive), 0);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R8 mask ones", int'(dout_drive), 31);
    for (int i = 0; i < DEPTH; i++) take();
    @(negedge clk);
    chk("R3 drained", int'(out_rdy), 0);
    chk("R2 in_rdy empty", int'(in_rdy), 1);

    // R9: paired transfers at the half-full boundary
    for (int i = 0; i < 32; i++) put(WIDTH'(i + 11), 1'b0);
    for (int i = 0; i < 6; i++) both(WIDTH'(i * 3 + 2));
    chk("R9 half_full held", int'(half_full), 1);
    for (int i = 0; i < 32; i++) take();

    // R10: reset with words stored
    for (int i = 0; i < 20; i++) put(WIDTH'(i), 1'b0);
    mrst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mrst_n = 1'b1;
    sb.delete();
    @(negedge clk);
    chk_empty("R10 cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule